// File: doc/BRIEF.md
# Serial Audio Bit-Clock Master Transmitter

This block serialises stereo audio for an external codec. It acts as the clock master on a three-wire serial audio link: it drives the bit clock, the word-select line and the serial data line. Packed 32-bit stereo words enter a small transmit FIFO. Each word holds two 16-bit samples. At the start of every 32-bit frame the block takes one word from the FIFO and shifts it out as two 16-bit channel slots.

The bit clock is made from the block clock, which is nominally a 12 MHz reference, by two cascaded integer dividers. Each divider field holds the divisor minus one. Software writes one configuration word. That word sets both divisors, which channel goes first, the bit order inside a slot, the transmit-start control, the clock-slave control and the reset controls. Software pulses the reset controls on and then off. A flag register records three events: a word taken from the FIFO, a write that was refused because the FIFO was full, and a frame that started with the FIFO empty. Software clears these flags by writing ones.

Top module: `i2s_tx`

## Requirements
- R1: After reset, bck is 1, ws is 0, sd is 0, fifo_full is 0 and irq_flags is 0.
- R2: While running, bck spends exactly (M+1)*(B+1) clock cycles in each level. M is configuration bits 21:16 and B is configuration bits 27:22.
- R3: A frame is 32 bit-clock periods. ws and sd change only on the clock edge where bck falls. The first falling bck edge after start begins a frame, and that frame's word is taken from the FIFO on the same edge.
- R4: Word bits 31:16 are the right sample and bits 15:0 are the left sample. Bits 0-15 of a frame carry the first channel and bits 16-31 carry the second. The first channel is right when configuration bit 6 is 1 and left when it is 0. ws is 1 for right and 0 for left, and it leads the data by one bit: during frame bit k, ws shows the channel of bit k+1 mod 32.
- R5: With configuration bit 7 set, each slot is sent MSB first (sample bit 15-j at slot position j). With bit 7 clear, each slot is sent LSB first (sample bit j at slot position j).
- R6: Configuration bit 8 enables transmission. While it is 0, bck stays at 1, no word is taken from the FIFO and sd is 0.
- R7: While configuration bit 4 (clock-slave) is 1, the block is not master and does not transmit: bck stays at 1 and no word is taken, even if bit 8 is set.
- R8: While configuration bit 0 is 1, the transmit core is held idle as in R6. While configuration bit 2 is 1, the FIFO is emptied and writes are refused. Bits 1 and 3 have no effect.
- R9: A frame that starts with an empty FIFO sends all zeros and sets irq_flags bit 5.
- R10: The FIFO holds DEPTH words, and fifo_full is 1 when it holds DEPTH words. A write while the FIFO is full is dropped and sets irq_flags bit 4.
- R11: Every word taken from the FIFO sets irq_flags bit 1. Writing irq_clr_we with a mask clears the masked flags. When a set and a clear hit the same flag in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word |
| fifo_wr | input | 1 | FIFO write strobe |
| fifo_wdata | input | 32 | Packed stereo word (right in 31:16, left in 15:0) |
| fifo_full | output | 1 | FIFO holds DEPTH words |
| irq_clr_we | input | 1 | Flag clear strobe |
| irq_clr_mask | input | 6 | Ones clear the matching flags |
| irq_flags | output | 6 | Bit 1 word taken, bit 4 write refused, bit 5 underrun |
| bck | output | 1 | Bit clock |
| ws | output | 1 | Word select (1 = right) |
| sd | output | 1 | Serial data |

## Verification
A FIFO write can land on the same clock edge that a frame takes a word from the FIFO. The bench provokes this by feeding words at random gaps while frames are being sent, keeping at least one word queued so that the result is unambiguous. It judges the outcome by checking that the serial stream carries every word, in order, with no loss and no repeat. A flag can also be set and cleared in the same cycle. The bench writes to a full FIFO in the very cycle that it clears the write-refused flag, and expects the flag to read back as set.

// File: rtl/i2s_tx.sv
module i2s_tx #(
  parameter int DEPTH = 8
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  input  logic        fifo_wr,
  input  logic [31:0] fifo_wdata,
  output logic        fifo_full,
  input  logic        irq_clr_we,
  input  logic [5:0]  irq_clr_mask,
  output logic [5:0]  irq_flags,
  output logic        bck,
  output logic        ws,
  output logic        sd
);
  localparam int DIVW = 6;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  logic [DIVW-1:0] mdiv_q, bdiv_q;
  logic rf_q, msbf_q, start_q, slave_q, trst_q, frst_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mdiv_q <= '0; bdiv_q <= '0;
      rf_q <= 1'b0; msbf_q <= 1'b0; start_q <= 1'b0;
      slave_q <= 1'b0; trst_q <= 1'b0; frst_q <= 1'b0;
    end else if (cfg_we) begin
      bdiv_q  <= cfg_wdata[27:22];
      mdiv_q  <= cfg_wdata[21:16];
      start_q <= cfg_wdata[8];
      msbf_q  <= cfg_wdata[7];
      rf_q    <= cfg_wdata[6];
      slave_q <= cfg_wdata[4];
      frst_q  <= cfg_wdata[2];
      trst_q  <= cfg_wdata[0];
    end

  wire unused_cfg = ^{cfg_wdata[31:28], cfg_wdata[15:9], cfg_wdata[5],
                      cfg_wdata[3], cfg_wdata[1]};

  wire run = start_q & ~slave_q & ~trst_q;

  // dividers
  logic [DIVW-1:0] mcnt, bcnt;
  wire mtick = run & (mcnt == mdiv_q);
  wire btick = mtick & (bcnt == bdiv_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mcnt <= '0; bcnt <= '0;
    end else if (!run) begin
      mcnt <= '0; bcnt <= '0;
    end else if (mtick) begin
      mcnt <= '0;
      bcnt <= (bcnt == bdiv_q) ? '0 : bcnt + 1'b1;
    end else begin
      mcnt <= mcnt + 1'b1;
    end

  // fifo
  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [4:0]    bit_cnt;
  logic [31:0]   word_q;

  wire fall        = btick & bck;
  wire frame_start = fall & (bit_cnt == 5'd31);
  wire fifo_empty  = (cnt == '0);
  assign fifo_full = (cnt == FULL_LVL);
  wire push     = fifo_wr & ~fifo_full & ~frst_q;
  wire pop      = frame_start & ~fifo_empty & ~frst_q;
  wire underrun = frame_start & (fifo_empty | frst_q);

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk)
    if (push) mem[wp] <= fifo_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (frst_q) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= ptr_inc(wp);
      if (pop)  rp <= ptr_inc(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end

  // serializer
  wire [31:0] src_word = frame_start ? (pop ? mem[rp] : 32'd0) : word_q;
  wire [4:0]  nk       = bit_cnt + 5'd1;
  wire [4:0]  nk_ws    = bit_cnt + 5'd2;
  wire [15:0] half     = (rf_q ^ nk[4]) ? src_word[31:16] : src_word[15:0];
  wire [3:0]  bidx     = msbf_q ? ~nk[3:0] : nk[3:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bck <= 1'b1; ws <= 1'b0; sd <= 1'b0;
      bit_cnt <= 5'd31; word_q <= '0;
    end else if (!run) begin
      bck <= 1'b1; ws <= rf_q; sd <= 1'b0;
      bit_cnt <= 5'd31;
    end else if (btick) begin
      bck <= ~bck;
      if (bck) begin
        bit_cnt <= nk;
        ws      <= rf_q ^ nk_ws[4];
        sd      <= half[bidx];
        if (frame_start) word_q <= src_word;
      end
    end

  // flags
  wire [5:0] set_v = {underrun, fifo_wr & fifo_full, 2'b00, pop, 1'b0};
  wire [5:0] clr_v = irq_clr_we ? irq_clr_mask : 6'd0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_flags <= '0;
    else        irq_flags <= (irq_flags & ~clr_v) | set_v;

endmodule

module i2s_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       run,
  input logic       bck,
  input logic       ws,
  input logic       sd,
  input logic       pop,
  input logic       underrun,
  input logic       fifo_wr,
  input logic       fifo_full,
  input logic [5:0] irq_flags
);
  // R6
  idle_bck_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> bck);
  // R3
  ws_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && !$stable(ws)) |-> $fell(bck));
  // R3
  sd_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && !$stable(sd)) |-> $fell(bck));
  // R9
  underrun_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> (irq_flags[5] && !sd));
  // R10
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && fifo_full) |=> irq_flags[4]);
  // R11
  pop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> irq_flags[1]);
endmodule

bind i2s_tx i2s_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .bck(bck), .ws(ws), .sd(sd),
  .pop(pop), .underrun(underrun), .fifo_wr(fifo_wr),
  .fifo_full(fifo_full), .irq_flags(irq_flags)
);

// File: tb/i2s_tx_bench.sv
`timescale 1ns/1ps
module i2s_tx_bench;
  localparam int DEPTH = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, fifo_wr = 0, irq_clr_we = 0;
  logic [31:0] cfg_wdata = 0, fifo_wdata = 0;
  logic [5:0] irq_clr_mask = 0, irq_flags;
  logic fifo_full, bck, ws, sd;

  always #2 clk = ~clk;

  i2s_tx #(.DEPTH(DEPTH)) u_i2s_tx (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .fifo_full(fifo_full),
    .irq_clr_we(irq_clr_we), .irq_clr_mask(irq_clr_mask), .irq_flags(irq_flags),
    .bck(bck), .ws(ws), .sd(sd));

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] q[$];
  int m = 0, b = 0;
  bit rf = 0, msbf = 0, exp_under = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cfgw(input bit st, input logic [3:0] extra);
    logic [31:0] v;
    v = 32'd0;
    v[27:22] = 6'(b); v[21:16] = 6'(m);
    v[8] = st; v[7] = msbf; v[6] = rf;
    v[4] = extra[3]; v[2] = extra[2]; v[1] = extra[1]; v[0] = extra[0];
    return v;
  endfunction

  function automatic logic ebit(input logic [31:0] w, input int k);
    logic [15:0] s;
    int j;
    s = (rf ^ (k >= 16)) ? w[31:16] : w[15:0];
    j = k % 16;
    return msbf ? s[15 - j] : s[j];
  endfunction

  function automatic logic ews(input int k);
    return rf ^ (((k + 1) % 32) >= 16);
  endfunction

  task automatic write_cfg(input logic [31:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic push(input logic [31:0] w, input bit clr4);
    @(negedge clk); fifo_wr = 1; fifo_wdata = w;
    irq_clr_we = clr4; irq_clr_mask = 6'h10;
    if (q.size() < DEPTH) q.push_back(w);
    @(negedge clk); fifo_wr = 0; irq_clr_we = 0;
  endtask

  task automatic clear_flags();
    @(negedge clk); irq_clr_we = 1; irq_clr_mask = 6'h3f;
    @(negedge clk); irq_clr_we = 0;
  endtask

  task automatic observe(input int nf);
    int falls, cyc, toggles, hp;
    logic pb;
    logic [31:0] cw;
    falls = 0; cyc = 0; toggles = 0; cw = 0;
    hp = (m + 1) * (b + 1);
    write_cfg(cfgw(1, 4'b0000));
    pb = bck;
    while (falls < nf * 32) begin
      @(negedge clk); cyc++;
      if (bck !== pb) begin
        // R2 half period
        if (toggles > 0) chk(cyc == hp, "R2 half period", cyc, hp);
        toggles++; cyc = 0;
        if (pb == 1'b1) begin
          int k;
          k = falls % 32;
          if (k == 0) begin
            if (q.size() > 0) cw = q.pop_front();
            else begin cw = 0; exp_under = 1; end
          end
          // R3 R4 R5 data and word select per bit
          chk(sd === ebit(cw, k), "R3 R4 R5 sd", {31'd0, sd}, {31'd0, ebit(cw, k)});
          chk(ws === ews(k), "R4 ws", {31'd0, ws}, {31'd0, ews(k)});
          falls++;
        end
        pb = bck;
      end
    end
    write_cfg(cfgw(0, 4'b0000));
  endtask

  task automatic feeder(input int n);
    for (int i = 0; i < n; i++) begin
      repeat (20 + ($urandom % 180)) @(negedge clk);
      if (q.size() >= 1 && q.size() <= DEPTH - 2) push($urandom, 0);
    end
  endtask

  task automatic hold_idle(input string req, input logic [31:0] v);
    int moved;
    moved = 0;
    clear_flags();
    write_cfg(v);
    repeat (200) begin
      @(negedge clk);
      if (bck !== 1'b1) moved++;
    end
    chk(moved == 0, req, moved, 0);
    chk(irq_flags[1] == 1'b0, req, {26'd0, irq_flags}, 0);
    write_cfg(cfgw(0, 4'b0000));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(bck === 1'b1 && ws === 1'b0 && sd === 1'b0, "R1 lines", {29'd0, bck, ws, sd}, 32'd4);
    chk(irq_flags === 6'd0 && fifo_full === 1'b0, "R1 flags", {25'd0, fifo_full, irq_flags}, 0);

    // R10 fill past capacity
    m = 1; b = 0; rf = 0; msbf = 1;
    write_cfg(cfgw(0, 4'b0000));
    for (int i = 0; i < DEPTH; i++) push(32'h1000_0001 * (i + 1), 0);
    chk(fifo_full === 1'b1, "R10 full", {31'd0, fifo_full}, 1);
    chk(irq_flags[4] === 1'b0, "R10 no drop yet", {26'd0, irq_flags}, 0);
    push(32'hDEAD_BEEF, 0);
    chk(irq_flags[4] === 1'b1, "R10 drop flag", {26'd0, irq_flags}, 32'h10);
    // R11 set wins over clear in same cycle
    push(32'hBAD0_BAD0, 1);
    chk(irq_flags[4] === 1'b1, "R11 set beats clear", {26'd0, irq_flags}, 32'h10);
    clear_flags();
    chk(irq_flags === 6'd0, "R11 clear", {26'd0, irq_flags}, 0);

    // R9 drain all and run one frame past
    exp_under = 0;
    observe(DEPTH + 1);
    chk(irq_flags[1] === 1'b1, "R11 pop flag", {26'd0, irq_flags}, 32'h2);
    chk(irq_flags[5] === exp_under, "R9 underrun flag", {26'd0, irq_flags}, {26'd0, exp_under, 5'd0});
    chk(fifo_full === 1'b0, "R10 drained", {31'd0, fifo_full}, 0);

    // random configurations with concurrent feeding
    for (int t = 0; t < 6; t++) begin
      m = (t == 0) ? 0 : $urandom % 4;
      b = (t == 0) ? 0 : $urandom % 4;
      rf = t[0]; msbf = t[1];
      clear_flags();
      write_cfg(cfgw(0, 4'b0000));
      for (int i = 0; i < 3; i++) push($urandom, 0);
      exp_under = 0;
      fork
        observe(4);
        feeder(5);
      join
      chk(irq_flags[5] === exp_under, "R9 flag random", {26'd0, irq_flags}, {26'd0, exp_under, 5'd0});
    end

    // R6 start clear, R7 slave, R8 core reset
    m = 0; b = 0;
    push(32'h1234_5678, 0);
    hold_idle("R6 stopped", cfgw(0, 4'b0000));
    hold_idle("R7 slave", cfgw(1, 4'b1000));
    hold_idle("R8 core reset", cfgw(1, 4'b0001));
    // R8 rx reset bits have no effect: word still there
    write_cfg(cfgw(0, 4'b0010));
    write_cfg(cfgw(0, 4'b0000));
    exp_under = 0;
    clear_flags();
    observe(1);
    chk(exp_under == 0 && irq_flags[5] === 1'b0, "R8 rx bits ignored", {26'd0, irq_flags}, 32'h2);
    // R8 FIFO flush
    for (int i = 0; i < 3; i++) push($urandom, 0);
    write_cfg(cfgw(0, 4'b0100));
    q.delete();
    write_cfg(cfgw(0, 4'b0000));
    clear_flags();
    exp_under = 0;
    observe(1);
    chk(irq_flags[5] === 1'b1, "R8 flush then underrun", {26'd0, irq_flags}, 32'h20);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule